// File: doc/BRIEF.md
# Bank-Selected Multiplexed Peripheral Bus Master

This block lets a small 8-bit controller reach peripherals over a narrow shared bus. Eight bidirectional lines carry either an address or a data byte. One extra bank line picks the left or the right bank, so there are 512 byte locations in total. The core never sends an address and data together. It first issues an address-select operation for one bank, and the block latches that bank and byte. Later data operations then read from or write to the location that was selected.

Each accepted request turns into exactly one bus phase in the following cycle. An address phase pulses the address strobe and drives the address. A write phase pulses the data strobe and drives the byte. A read phase pulses the data strobe, releases the lines, and samples the incoming byte. That byte comes back to the core one cycle later. Requests may arrive on consecutive cycles, so several data accesses can follow a single selection back to back.

Top module: `sidebank_bus_master`

## Requirements
- R1: After reset, `bank_sel` is 0 (left), `sel_loc` is 0, both strobes are low, `bus_oe` is 0 and `rsp_valid` is 0.
- R2: A request with `req_op` = 0 (select left) produces, in the next cycle only, `addr_stb` = 1 with `bus_oe` = 1, `bus_out` = the request byte and `bank_sel` = 0. From that cycle on, `sel_loc` = {1'b0, byte}.
- R3: A request with `req_op` = 1 (select right) behaves as in R2 but sets `bank_sel` = 1 and `sel_loc` = {1'b1, byte}. The bank line changes only in a cycle that carries an address phase.
- R4: A request with `req_op` = 3 (write) produces, in the next cycle only, `data_stb` = 1, `bus_rd` = 0, `bus_oe` = 1 and `bus_out` = the request byte. `bank_sel` and `sel_loc` are unchanged.
- R5: A request with `req_op` = 2 (read) produces, in the next cycle only, `data_stb` = 1, `bus_rd` = 1 and `bus_oe` = 0. `bus_in` is sampled in that cycle and returned on `rsp_data`, with `rsp_valid` = 1, in the cycle after it.
- R6: Any number of data requests after one selection, including back-to-back ones, all address the same location, and `sel_loc` stays constant across them.
- R7: The two strobes are never high together. A cycle that follows a cycle with no accepted request shows no strobe and `bus_oe` = 0.
- R8: If a select request arrives in the cycle in which a read phase is on the bus, the read returns the byte of the previously selected location. The new selection applies from the following phase on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core presents an operation this cycle |
| req_op | input | 2 | 0 select left, 1 select right, 2 read, 3 write |
| req_byte | input | 8 | Address for selects, data for writes |
| bus_in | input | 8 | Byte sampled from the shared lines |
| bus_out | output | 8 | Byte driven onto the shared lines |
| bus_oe | output | 1 | Block drives the shared lines |
| bank_sel | output | 1 | Bank line, 0 left, 1 right |
| addr_stb | output | 1 | Address phase strobe |
| data_stb | output | 1 | Data phase strobe |
| bus_rd | output | 1 | Current data phase is a read |
| sel_loc | output | 9 | Held {bank, address} |
| rsp_valid | output | 1 | Read byte available |
| rsp_data | output | 8 | Read byte |

## Verification
Two functions can fall in the same cycle here: a read phase that is sampling the bus, and a new address selection that updates the bank and address registers. The bench issues a read and then, in the very next cycle, a select of the other bank at a different address. This places the selection exactly on the read phase. The check is that the returned byte is the one stored at the earlier location in the bench's peripheral model, and that a following read returns the byte of the new location.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

    typedef enum logic [1:0] {
        OP_SEL_L = 2'd0,
        OP_SEL_R = 2'd1,
        OP_READ  = 2'd2,
        OP_WRITE = 2'd3
    } sbus_op_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_RD   = 2'd2,
        PH_WR   = 2'd3
    } sbus_phase_e;

endpackage

// File: rtl/sbus_decode.sv
module sbus_decode
    import sbus_pkg::*;
(
    input  logic       req_valid,
    input  logic [1:0] req_op,
    output logic       is_sel,
    output logic       sel_bank,
    output logic       is_data,
    output logic       is_read
);
    sbus_op_e op;

    always_comb begin
        op       = sbus_op_e'(req_op);
        is_sel   = req_valid && (op == OP_SEL_L || op == OP_SEL_R);
        sel_bank = (op == OP_SEL_R);
        is_data  = req_valid && (op == OP_READ || op == OP_WRITE);
        is_read  = (op == OP_READ);
    end
endmodule

// File: rtl/sbus_sel_reg.sv
module sbus_sel_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         load_bank,
    input  logic [W-1:0] load_addr,
    output logic         bank,
    output logic [W-1:0] addr
);
    typedef struct packed {
        logic         bank;
        logic [W-1:0] addr;
    } sel_t;

    sel_t sel_d, sel_q;

    always_comb begin
        sel_d = sel_q;
        if (load) begin
            sel_d.bank = load_bank;
            sel_d.addr = load_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_d;
    end

    assign bank = sel_q.bank;
    assign addr = sel_q.addr;
endmodule

// File: rtl/sbus_phase_gen.sv
module sbus_phase_gen
    import sbus_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_sel,
    input  logic         start_data,
    input  logic         data_rd,
    input  logic [W-1:0] byte_in,
    output logic         addr_stb,
    output logic         data_stb,
    output logic         rd_phase,
    output logic         drive_en,
    output logic [W-1:0] drive_val
);
    typedef struct packed {
        sbus_phase_e  phase;
        logic [W-1:0] val;
    } ph_t;

    ph_t ph_d, ph_q;

    always_comb begin
        ph_d.phase = PH_IDLE;
        ph_d.val   = ph_q.val;
        if (start_sel) begin
            ph_d.phase = PH_ADDR;
            ph_d.val   = byte_in;
        end else if (start_data) begin
            ph_d.phase = data_rd ? PH_RD : PH_WR;
            if (!data_rd) ph_d.val = byte_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= '{phase: PH_IDLE, val: '0};
        else        ph_q <= ph_d;
    end

    assign addr_stb  = (ph_q.phase == PH_ADDR);
    assign data_stb  = (ph_q.phase == PH_RD) || (ph_q.phase == PH_WR);
    assign rd_phase  = (ph_q.phase == PH_RD);
    assign drive_en  = (ph_q.phase == PH_ADDR) || (ph_q.phase == PH_WR);
    assign drive_val = ph_q.val;
endmodule

// File: rtl/sbus_rd_capture.sv
module sbus_rd_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_phase,
    input  logic [W-1:0] bus_in,
    output logic         rsp_valid,
    output logic [W-1:0] rsp_data
);
    typedef struct packed {
        logic         vld;
        logic [W-1:0] dat;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d.vld = rd_phase;
        cap_d.dat = rd_phase ? bus_in : cap_q.dat;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign rsp_valid = cap_q.vld;
    assign rsp_data  = cap_q.dat;
endmodule

// File: rtl/sidebank_bus_master.sv
module sidebank_bus_master #(
    parameter int W     = 8,
    localparam int LOCW = W + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [1:0]      req_op,
    input  logic [W-1:0]    req_byte,
    input  logic [W-1:0]    bus_in,
    output logic [W-1:0]    bus_out,
    output logic            bus_oe,
    output logic            bank_sel,
    output logic            addr_stb,
    output logic            data_stb,
    output logic            bus_rd,
    output logic [LOCW-1:0] sel_loc,
    output logic            rsp_valid,
    output logic [W-1:0]    rsp_data
);
    logic         is_sel, sel_bank, is_data, is_read;
    logic [W-1:0] held_addr;

    sbus_decode u_dec (
        .req_valid (req_valid),
        .req_op    (req_op),
        .is_sel    (is_sel),
        .sel_bank  (sel_bank),
        .is_data   (is_data),
        .is_read   (is_read)
    );

    sbus_sel_reg #(.W(W)) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (is_sel),
        .load_bank (sel_bank),
        .load_addr (req_byte),
        .bank      (bank_sel),
        .addr      (held_addr)
    );

    sbus_phase_gen #(.W(W)) u_ph (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_sel  (is_sel),
        .start_data (is_data),
        .data_rd    (is_read),
        .byte_in    (req_byte),
        .addr_stb   (addr_stb),
        .data_stb   (data_stb),
        .rd_phase   (bus_rd),
        .drive_en   (bus_oe),
        .drive_val  (bus_out)
    );

    sbus_rd_capture #(.W(W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_phase  (bus_rd),
        .bus_in    (bus_in),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    assign sel_loc = {bank_sel, held_addr};
endmodule

// File: rtl/sidebank_bus_master_chk.sv
module sidebank_bus_master_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] bus_out,
    input logic         bus_oe,
    input logic         bank_sel,
    input logic         addr_stb,
    input logic         data_stb,
    input logic         bus_rd,
    input logic [W:0]   sel_loc,
    input logic         rsp_valid
);
    assert_addr_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_stb |-> (bus_oe && bus_out == sel_loc[W-1:0]));

    assert_bank_moves_on_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bank_sel) || $fell(bank_sel)) |-> addr_stb);

    assert_write_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_stb && !bus_rd) |-> bus_oe);

    assert_read_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_stb && bus_rd) |-> !bus_oe);

    assert_rsp_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(data_stb && bus_rd));

    assert_loc_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        data_stb |-> ($stable(sel_loc) && $stable(bank_sel)));

    assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_stb && data_stb));

    assert_idle_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_stb || data_stb) |-> !bus_oe);
endmodule

bind sidebank_bus_master sidebank_bus_master_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_out   (bus_out),
    .bus_oe    (bus_oe),
    .bank_sel  (bank_sel),
    .addr_stb  (addr_stb),
    .data_stb  (data_stb),
    .bus_rd    (bus_rd),
    .sel_loc   (sel_loc),
    .rsp_valid (rsp_valid)
);

// File: tb/sidebank_bus_master_bench.sv
module sidebank_bus_master_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic [7:0] req_byte = 8'd0;
    logic [7:0] bus_in;
    logic [7:0] bus_out;
    logic       bus_oe, bank_sel, addr_stb, data_stb, bus_rd, rsp_valid;
    logic [8:0] sel_loc;
    logic [7:0] rsp_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    sidebank_bus_master u_sidebank_bus_master (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_byte(req_byte), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .bank_sel(bank_sel), .addr_stb(addr_stb), .data_stb(data_stb),
        .bus_rd(bus_rd), .sel_loc(sel_loc), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    // registered peripheral model: one address latch per bank
    logic [7:0] mem [512];
    logic [7:0] lat_l = 8'd0, lat_r = 8'd0;

    function automatic logic [7:0] init_val(int loc);
        return 8'((loc * 7 + 3) & 255);
    endfunction

    initial for (int i = 0; i < 512; i++) mem[i] = init_val(i);

    always @(posedge clk) begin
        if (addr_stb) begin
            if (bank_sel) lat_r <= bus_out;
            else          lat_l <= bus_out;
        end
        if (data_stb && !bus_rd && bus_oe)
            mem[{bank_sel, bank_sel ? lat_r : lat_l}] <= bus_out;
    end

    assign bus_in = mem[{bank_sel, bank_sel ? lat_r : lat_l}];

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put(logic [1:0] op, logic [7:0] b);
        req_valid = 1'b1;
        req_op    = op;
        req_byte  = b;
    endtask

    task automatic idle();
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 bank", bank_sel, 0);
        check("R1 loc", sel_loc, 0);
        check("R1 strobes", {addr_stb, data_stb}, 0);
        check("R1 oe", bus_oe, 0);
        check("R1 rsp_valid", rsp_valid, 0);
    endtask

    task automatic t_select_left();
        @(negedge clk); put(2'd0, 8'h33);
        @(negedge clk); idle();
        check("R2 addr_stb", addr_stb, 1);
        check("R2 data_stb", data_stb, 0);
        check("R2 bus_out", bus_out, 8'h33);
        check("R2 oe", bus_oe, 1);
        check("R2 bank", bank_sel, 0);
        check("R2 loc", sel_loc, 9'h033);
        @(negedge clk);
        check("R7 idle strobes", {addr_stb, data_stb}, 0);
        check("R7 idle oe", bus_oe, 0);
        check("R2 loc held", sel_loc, 9'h033);
    endtask

    task automatic t_select_right();
        @(negedge clk); put(2'd1, 8'hC5);
        @(negedge clk); idle();
        check("R3 addr_stb", addr_stb, 1);
        check("R3 bank", bank_sel, 1);
        check("R3 bus_out", bus_out, 8'hC5);
        check("R3 loc", sel_loc, 9'h1C5);
    endtask

    task automatic t_write_read();
        @(negedge clk); put(2'd1, 8'h10);
        @(negedge clk); put(2'd3, 8'hA7);
        @(negedge clk); idle();
        check("R4 data_stb", data_stb, 1);
        check("R4 addr_stb", addr_stb, 0);
        check("R4 rd", bus_rd, 0);
        check("R4 oe", bus_oe, 1);
        check("R4 bus_out", bus_out, 8'hA7);
        check("R4 loc", sel_loc, 9'h110);
        @(negedge clk); put(2'd2, 8'h00);
        @(negedge clk); idle();
        check("R5 data_stb", data_stb, 1);
        check("R5 rd", bus_rd, 1);
        check("R5 oe released", bus_oe, 0);
        check("R5 no early rsp", rsp_valid, 0);
        @(negedge clk);
        check("R5 rsp_valid", rsp_valid, 1);
        check("R5 rsp_data", rsp_data, 8'hA7);
        @(negedge clk);
        check("R5 rsp one cycle", rsp_valid, 0);
    endtask

    task automatic t_repeat();
        @(negedge clk); put(2'd0, 8'h20);
        @(negedge clk); put(2'd3, 8'h11);
        @(negedge clk); put(2'd3, 8'h22);
        check("R6 loc first write", sel_loc, 9'h020);
        @(negedge clk); put(2'd2, 8'h00);
        check("R6 loc second write", sel_loc, 9'h020);
        check("R6 second write data", bus_out, 8'h22);
        @(negedge clk); put(2'd2, 8'h00);
        check("R6 loc read", sel_loc, 9'h020);
        @(negedge clk); idle();
        check("R6 first rsp valid", rsp_valid, 1);
        check("R6 first rsp", rsp_data, 8'h22);
        check("R7 back-to-back strobe", data_stb, 1);
        @(negedge clk);
        check("R6 second rsp valid", rsp_valid, 1);
        check("R6 second rsp", rsp_data, 8'h22);
    endtask

    task automatic t_overlap();
        @(negedge clk); put(2'd0, 8'h40);
        @(negedge clk); put(2'd2, 8'h00);
        @(negedge clk); put(2'd1, 8'h41);
        check("R8 read phase bank", bank_sel, 0);
        check("R8 read phase strobe", data_stb, 1);
        @(negedge clk); put(2'd2, 8'h00);
        check("R8 old location byte", rsp_data, init_val(9'h040));
        check("R8 rsp valid", rsp_valid, 1);
        check("R8 new addr phase", {addr_stb, bank_sel, bus_out}, {2'b11, 8'h41});
        @(negedge clk); idle();
        @(negedge clk);
        check("R8 new location byte", rsp_data, init_val(9'h141));
        check("R8 loc", sel_loc, 9'h141);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_select_left();
        t_select_right();
        t_write_read();
        t_repeat();
        t_overlap();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule